// File: doc/BRIEF.md
# Single-Step Non-Restoring Division Unit

This block performs one step of a non-restoring binary division per command and keeps three status flags between steps: a quotient-sign flag (Q), a divisor-sign flag (M) and a shift/quotient bit (T). A setup command prepares the flags for an unsigned or a signed division. Each step command takes a partial remainder and a divisor and returns the new partial remainder, updating Q and T. A separate command loads T from an input bit, so that a sequencer can feed dividend bits into the remainder and collect quotient bits out of T.

An unsigned division of an N-bit dividend by an N-bit divisor runs as follows. Start with a zero remainder, do the unsigned setup, and then repeat N times: rotate the dividend left through T (T takes the dividend's top bit and the old T enters its bottom bit), load that bit into the unit, and step. A final rotation leaves the quotient in the dividend register. Correcting the remainder and fixing the quotient sign are left to the caller.

All commands take effect at the rising clock edge on which they are presented. Outputs are registered and show the result from that edge onward.

Top module: `divstep_unit`

## Requirements
- R1: After an asynchronous active-low reset, remOut, qFlag, mFlag and tFlag are all 0.
- R2: Command code 1 (unsigned setup) clears qFlag, mFlag and tFlag and leaves remOut unchanged.
- R3: Command code 2 (signed setup) sets qFlag to opA bit WIDTH-1, sets mFlag to opB bit WIDTH-1, sets tFlag to their XOR, and leaves remOut unchanged.
- R4: On command code 3 (step), the working value is opA shifted left by one, with the tFlag held before the step placed in bit 0. The old bit WIDTH-1 of opA is dropped from the working value and kept as the captured top bit.
- R5: On a step, if the previous qFlag equals mFlag, remOut becomes the working value minus opB modulo 2^WIDTH. Otherwise remOut becomes the working value plus opB modulo 2^WIDTH.
- R6: On a step, the new qFlag is the captured top bit XOR the borrow (subtract case) or carry (add case) XOR mFlag.
- R7: On a step, the new tFlag is 1 exactly when the new qFlag equals mFlag. mFlag is not changed by a step.
- R8: Command code 4 (load T) sets tFlag to opA bit 0 and leaves remOut, qFlag and mFlag unchanged.
- R9: Command codes 0, 5, 6 and 7 change no output.
- R10: WIDTH steps after an unsigned setup, with the dividend rotated through T before each step and once after the last, leave the integer quotient of dividend divided by a nonzero divisor in the rotated register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| cmd | input | 3 | Command: 0 none, 1 unsigned setup, 2 signed setup, 3 step, 4 load T, 5-7 none |
| opA | input | WIDTH | Partial remainder for a step; dividend for signed setup; bit 0 is the T value for load T |
| opB | input | WIDTH | Divisor |
| remOut | output | WIDTH | Partial remainder from the latest step |
| qFlag | output | 1 | Q status flag |
| mFlag | output | 1 | M status flag |
| tFlag | output | 1 | T status flag |

## Verification
The bench runs a 5-bit configuration. It drives every remainder and divisor value under all eight combinations of Q, M and T. This catches a design that picks add or subtract from the wrong flags, feeds the wrong bit into the LSB, or confuses carry with borrow. Any of these shows up as a wrong remOut or a flipped Q in some quadrant, for example when the divisor is larger than the shifted value, or when the add wraps. It also divides every dividend by every nonzero divisor through the rotate-and-step sequence, where a wrong T rule corrupts the quotient. Finally it checks that the reserved command codes and load T leave the other state alone, and that the signed setup derives T from both sign bits.

// File: rtl/divstep_pkg.sv
package divstep_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_SETU = 3'd1,
    CMD_SETS = 3'd2,
    CMD_STEP = 3'd3,
    CMD_LDT  = 3'd4
  } divCmd_e;

  // strobes from control to datapath, at most one set per cycle
  typedef struct packed {
    logic clrFlags;
    logic loadSigns;
    logic doStep;
    logic loadT;
  } divCtrl_t;

endpackage

// File: rtl/divstep_addsub.sv
module divstep_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  logic             subSel,
  output logic [WIDTH-1:0] resOut,
  output logic             cbOut
);
  localparam int EXT = WIDTH + 1;

  logic [WIDTH-1:0] bOp;
  logic [EXT-1:0]   sumExt;

  assign bOp    = subSel ? ~bIn : bIn;
  assign sumExt = {1'b0, aIn} + {1'b0, bOp} + {{WIDTH{1'b0}}, subSel};
  assign resOut = sumExt[WIDTH-1:0];
  // carry for add, borrow (inverted carry) for subtract
  assign cbOut  = subSel ? ~sumExt[WIDTH] : sumExt[WIDTH];
endmodule

// File: rtl/divstep_ctrl.sv
module divstep_ctrl
  import divstep_pkg::*;
(
  input  logic [2:0] cmd,
  output divCtrl_t   ctrl
);
  always_comb begin
    ctrl = '0;
    case (cmd)
      CMD_SETU: ctrl.clrFlags  = 1'b1;
      CMD_SETS: ctrl.loadSigns = 1'b1;
      CMD_STEP: ctrl.doStep    = 1'b1;
      CMD_LDT:  ctrl.loadT     = 1'b1;
      default:  ctrl = '0;
    endcase
  end
endmodule

// File: rtl/divstep_datapath.sv
module divstep_datapath
  import divstep_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  divCtrl_t         ctrl,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] remOut,
  output logic             qFlag,
  output logic             mFlag,
  output logic             tFlag
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] remReg;
  logic             qReg, mReg, tReg;
  logic [WIDTH-1:0] shifted;
  logic [WIDTH-1:0] stepRes;
  logic             doSub, carryBorrow, topBit, nextQ, nextT;

  assign topBit  = opA[MSB];
  assign shifted = {opA[MSB-1:0], tReg};
  assign doSub   = (qReg == mReg);

  divstep_addsub #(.WIDTH(WIDTH)) uAddSub (
    .aIn   (shifted),
    .bIn   (opB),
    .subSel(doSub),
    .resOut(stepRes),
    .cbOut (carryBorrow)
  );

  assign nextQ = topBit ^ carryBorrow ^ mReg;
  assign nextT = (nextQ == mReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remReg <= '0;
      qReg   <= 1'b0;
      mReg   <= 1'b0;
      tReg   <= 1'b0;
    end else if (ctrl.clrFlags) begin
      qReg <= 1'b0;
      mReg <= 1'b0;
      tReg <= 1'b0;
    end else if (ctrl.loadSigns) begin
      qReg <= opA[MSB];
      mReg <= opB[MSB];
      tReg <= opA[MSB] ^ opB[MSB];
    end else if (ctrl.doStep) begin
      remReg <= stepRes;
      qReg   <= nextQ;
      tReg   <= nextT;
    end else if (ctrl.loadT) begin
      tReg <= opA[0];
    end
  end

  assign remOut = remReg;
  assign qFlag  = qReg;
  assign mFlag  = mReg;
  assign tFlag  = tReg;
endmodule

// File: rtl/divstep_unit.sv
module divstep_unit
  import divstep_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       cmd,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] remOut,
  output logic             qFlag,
  output logic             mFlag,
  output logic             tFlag
);
  divCtrl_t ctrl;

  divstep_ctrl uCtrl (
    .cmd (cmd),
    .ctrl(ctrl)
  );

  divstep_datapath #(.WIDTH(WIDTH)) uDp (
    .clk   (clk),
    .rstN  (rstN),
    .ctrl  (ctrl),
    .opA   (opA),
    .opB   (opB),
    .remOut(remOut),
    .qFlag (qFlag),
    .mFlag (mFlag),
    .tFlag (tFlag)
  );
endmodule

// File: rtl/divstep_chk.sv
module divstep_chk
  import divstep_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       cmd,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [WIDTH-1:0] remOut,
  input logic             qFlag,
  input logic             mFlag,
  input logic             tFlag
);
  logic [WIDTH-1:0] shiftNow;
  logic [WIDTH:0]   subW, addW;
  logic             isSub, predCb, predQ;
  logic [WIDTH-1:0] predRem;
  logic             isStep, isSetU, isSetS, isLdT, isIdle;

  assign shiftNow = {opA[WIDTH-2:0], tFlag};
  assign subW     = {1'b0, shiftNow} - {1'b0, opB};
  assign addW     = {1'b0, shiftNow} + {1'b0, opB};
  assign isSub    = (qFlag == mFlag);
  assign predRem  = isSub ? subW[WIDTH-1:0] : addW[WIDTH-1:0];
  assign predCb   = isSub ? subW[WIDTH] : addW[WIDTH];
  assign predQ    = opA[WIDTH-1] ^ predCb ^ mFlag;

  assign isStep = (cmd == CMD_STEP);
  assign isSetU = (cmd == CMD_SETU);
  assign isSetS = (cmd == CMD_SETS);
  assign isLdT  = (cmd == CMD_LDT);
  assign isIdle = (cmd == CMD_NOP) || (cmd > CMD_LDT);

  // R2
  setu_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    isSetU |=> (!qFlag && !mFlag && !tFlag && $stable(remOut)));

  // R3
  sets_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    isSetS |=> (qFlag == $past(opA[WIDTH-1]) && mFlag == $past(opB[WIDTH-1])
                && tFlag == (qFlag ^ mFlag)));

  // R5
  step_rem_chk: assert property (@(posedge clk) disable iff (!rstN)
    isStep |=> remOut == $past(predRem));

  // R6
  step_q_chk: assert property (@(posedge clk) disable iff (!rstN)
    isStep |=> qFlag == $past(predQ));

  // R7
  step_t_chk: assert property (@(posedge clk) disable iff (!rstN)
    isStep |=> ((tFlag == (qFlag == mFlag)) && $stable(mFlag)));

  // R8
  loadt_chk: assert property (@(posedge clk) disable iff (!rstN)
    isLdT |=> (tFlag == $past(opA[0]) && $stable(qFlag) && $stable(mFlag)
               && $stable(remOut)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    isIdle |=> ($stable(remOut) && $stable(qFlag) && $stable(mFlag) && $stable(tFlag)));
endmodule

bind divstep_unit divstep_chk #(.WIDTH(WIDTH)) uChk (
  .clk   (clk),
  .rstN  (rstN),
  .cmd   (cmd),
  .opA   (opA),
  .opB   (opB),
  .remOut(remOut),
  .qFlag (qFlag),
  .mFlag (mFlag),
  .tFlag (tFlag)
);

// File: tb/sim_divstep_unit.sv
`timescale 1ns/1ps
module sim_divstep_unit;
  localparam int W    = 5;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [2:0]   cmd = 3'd0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [W-1:0] remOut;
  logic         qFlag, mFlag, tFlag;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  divstep_unit #(.WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .cmd(cmd), .opA(opA), .opB(opB),
    .remOut(remOut), .qFlag(qFlag), .mFlag(mFlag), .tFlag(tFlag)
  );

  // present a command for one edge, return with outputs settled
  task automatic issue(input logic [2:0] c, input int a, input int b);
    @(negedge clk);
    cmd = c; opA = W'(a); opB = W'(b);
    @(negedge clk);
    cmd = 3'd0;
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int packOut();
    return (int'(remOut) << 3) | (int'(qFlag) << 2) | (int'(mFlag) << 1) | int'(tFlag);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int snap;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", packOut(), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", packOut(), 0);

    // R3 signed setup, all sign combinations
    for (int s = 0; s < 4; s++) begin
      int qa, mb;
      qa = s & 1; mb = s >> 1;
      issue(3'd2, (qa << (W-1)) | 3, (mb << (W-1)) | 1);
      check("R3 q/m/t", {qFlag, mFlag, tFlag}, {qa[0], mb[0], qa[0] ^ mb[0]});
    end
    // leave a nonzero remainder for the hold checks
    issue(3'd4, 1, 0);
    issue(3'd3, 9, 3);
    snap = packOut();
    // R9 reserved and idle codes
    issue(3'd0, 31, 31); check("R9 code0", packOut(), snap);
    issue(3'd5, 31, 31); check("R9 code5", packOut(), snap);
    issue(3'd6, 0, 31);  check("R9 code6", packOut(), snap);
    issue(3'd7, 30, 0);  check("R9 code7", packOut(), snap);
    // R8 load T, others untouched
    issue(3'd4, (tFlag ? 0 : 1) | 6, 5);
    check("R8 load T", packOut(), snap ^ 1);
    issue(3'd4, 30, 5);
    check("R8 load T zero", packOut(), snap & ~1);
    // R2 unsigned setup clears flags, keeps remainder
    issue(3'd2, 16, 16);
    issue(3'd4, 1, 0);
    issue(3'd1, 31, 31);
    check("R2 clear", packOut(), snap & ~7);

    // R4 R5 R6 R7 exhaustive step sweep over flags and operands
    for (int f = 0; f < 8; f++) begin
      for (int a = 0; a <= MASK; a++) begin
        for (int b = 0; b <= MASK; b++) begin
          int q0, m0, t0, sh, raw, cb, eRem, eQ, eT;
          q0 = f & 1; m0 = (f >> 1) & 1; t0 = (f >> 2) & 1;
          issue(3'd2, q0 << (W-1), m0 << (W-1));
          issue(3'd4, t0, 0);
          issue(3'd3, a, b);
          sh = ((a << 1) | t0) & MASK;
          if (q0 == m0) begin
            raw = sh - b;
            cb = (raw < 0) ? 1 : 0;
          end else begin
            raw = sh + b;
            cb = (raw > MASK) ? 1 : 0;
          end
          eRem = raw & MASK;
          eQ = ((a >> (W-1)) & 1) ^ cb ^ m0;
          eT = (eQ == m0) ? 1 : 0;
          check("R4 R5 R6 R7 step", packOut(), (eRem << 3) | (eQ << 2) | (m0 << 1) | eT);
        end
      end
    end

    // R10 full unsigned division through rotate-and-step
    for (int dvd = 0; dvd <= MASK; dvd++) begin
      for (int dvs = 1; dvs <= MASK; dvs++) begin
        int x, r, bitIn;
        x = dvd; r = 0;
        issue(3'd1, 0, 0);
        for (int i = 0; i < W; i++) begin
          bitIn = (x >> (W-1)) & 1;
          x = ((x << 1) | int'(tFlag)) & MASK;
          issue(3'd4, bitIn, 0);
          issue(3'd3, r, dvs);
          r = int'(remOut);
        end
        x = ((x << 1) | int'(tFlag)) & MASK;
        check("R10 quotient", x, dvd / dvs);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule